// File: doc/BRIEF.md
# Parallel I/O Host Register Decoder

This block is the processor-side register front end of a 24-bit parallel I/O unit made of three byte-wide ports. A host reaches it through an active-low chip select, active-low read and write strobes, a 2-bit register address and an 8-bit data bus. Address 0 selects port A, address 1 selects port B, address 2 selects port C and address 3 selects the control register. Port C is split into an upper and a lower nibble. Group A is port A together with the upper nibble of C. Group B is port B together with the lower nibble of C.

A byte written to the control address has two formats, and bit 7 chooses between them. A mode word sets the operating mode and pin directions of both groups and clears every output latch. A bit command sets or clears one bit of port C. When a group is in a strobed mode, a bit command aimed at that group's handshake position also loads the matching interrupt-enable flip-flop. Reads of the three port addresses return the pin value for an input and the latch value for an output. The handshake sequencing that uses these enables is not part of this block.

Writes are sampled on every rising clock edge while chip select and the write strobe are low and the read strobe is high. Writing the same value again has no further effect. Read data is combinational.

Top module: `pio_ctrl_decoder`

## Requirements
- R1: A write to address 0, 1 or 2 stores the data byte in the output latch of port A, B or C. The new value is visible on `out_a`, `out_b` or `out_c` after the next clock edge.
- R2: While `cs_n` is high, no write changes any register and `rdata_oe` stays low.
- R3: A control write with bit 7 = 1 is a mode word, and its fields load as follows.
  - Bits 6:5 set `grp_a_mode`: 00 gives code 0, 01 gives code 1, and 10 or 11 give code 2.
  - Bit 2 sets `grp_b_mode`.
  - Bits 4, 3, 1 and 0 set `a_is_in`, `ch_is_in`, `b_is_in` and `cl_is_in`, where 1 means input.
- R4: A mode word clears all three output latches to zero.
- R5: A control write with bit 7 = 0 is a bit command. Bits 3:1 select bit 0 to 7 of port C and bit 0 is the new value. Only the selected bit changes, and bits 6:4 have no effect.
- R6: Some bit commands also load an interrupt-enable flip-flop, and otherwise these flip-flops hold their values.
  - When `grp_a_mode` is not 0, a bit command on bit 4 loads `inte_a_in` and one on bit 6 loads `inte_a_out`.
  - When `grp_b_mode` is 1, a bit command on bit 2 loads `inte_b`.
- R7: Reading address 0 or 1 returns the pins of port A or B when that port is an input, and its latch otherwise. Reading address 2 makes this choice separately for each nibble of port C.
- R8: `rdata_oe` is high only while `cs_n` and `rd_n` are both low and the address is not 3. Whenever `rdata_oe` is low, `rdata` is zero.
- R9: After reset, both groups are in mode 0, all four direction outputs are 1, and all latches and interrupt enables are 0.
- R10: A write strobe is ignored while `rd_n` is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| rdata_oe | output | 1 | Enable for the host data bus driver |
| pin_a | input | 8 | Pin levels of port A |
| pin_b | input | 8 | Pin levels of port B |
| pin_c | input | 8 | Pin levels of port C |
| grp_a_mode | output | 2 | Group A mode code 0, 1 or 2 |
| grp_b_mode | output | 1 | Group B mode (0 or 1) |
| a_is_in | output | 1 | Port A is an input |
| ch_is_in | output | 1 | Upper nibble of port C is an input |
| b_is_in | output | 1 | Port B is an input |
| cl_is_in | output | 1 | Lower nibble of port C is an input |
| out_a | output | 8 | Port A output latch |
| out_b | output | 8 | Port B output latch |
| out_c | output | 8 | Port C output latch |
| inte_a_in | output | 1 | Group A input interrupt enable |
| inte_a_out | output | 1 | Group A output interrupt enable |
| inte_b | output | 1 | Group B interrupt enable |

## Verification
The assertions check the following on every cycle:
- that registers stay unchanged while the block is not selected or the two strobes collide;
- that a mode word leaves all latches at zero;
- that a bit command touches only one bit of port C;
- that the interrupt enables move only in strobed modes;
- that the bus enable obeys its decode.

Only the bench scenarios can show that each mode-word field lands on the correct output, including the two encodings of mode 2. They also show the per-nibble pin-or-latch choice on port C reads and the complete reset state. Constrained-random sequences that mix mode words, bit commands and port accesses compare every output against a bench model after each write.

// File: rtl/pio_pkg.sv
// Shared types and sizes for the parallel I/O register decoder.
// Assumes a byte-wide host bus and ports split into two nibble halves.
package pio_pkg;
    localparam int PIO_DW   = 8;
    localparam int PIO_NW   = PIO_DW / 2;
    localparam int PIO_SELW = $clog2(PIO_DW);
    localparam int PIO_NPORT = 3;

    typedef enum logic [1:0] {
        SEL_PA  = 2'b00,
        SEL_PB  = 2'b01,
        SEL_PC  = 2'b10,
        SEL_CTL = 2'b11
    } pio_sel_e;

    typedef enum logic [1:0] {
        GA_BASIC   = 2'd0,
        GA_STROBED = 2'd1,
        GA_BIDIR   = 2'd2
    } ga_mode_e;

    typedef struct packed {
        ga_mode_e a_mode;
        logic     a_in;
        logic     ch_in;
        logic     b_mode;
        logic     b_in;
        logic     cl_in;
    } pio_cfg_t;

    localparam pio_cfg_t PIO_CFG_RST = '{a_mode: GA_BASIC, a_in: 1'b1, ch_in: 1'b1,
                                         b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/pio_bus_decode.sv
// Host access decoder: turns strobes and address into per-register write pulses.
// Assumes strobes are already synchronous to clk; a write needs rd_n high.
module pio_bus_decode
    import pio_pkg::*;
#(
    parameter int NPORT = PIO_NPORT
) (
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [1:0]       addr,
    input  logic             fmt_bit,
    output logic [NPORT-1:0] wr_lat,
    output logic             wr_mode,
    output logic             wr_bit,
    output logic             rd_drive
);
    logic wr_act;

    // Qualified write: selected, writing, and not colliding with a read.
    assign wr_act = !cs_n && !wr_n && rd_n;

    // One write pulse per port latch.
    for (genvar g = 0; g < NPORT; g++) begin : g_port_wr
        assign wr_lat[g] = wr_act && (addr == 2'(g));
    end

    // Split the control address into its two command formats.
    assign wr_mode = wr_act && (addr == SEL_CTL) && fmt_bit;
    assign wr_bit  = wr_act && (addr == SEL_CTL) && !fmt_bit;

    // Read drive is legal only for the port addresses.
    assign rd_drive = !cs_n && !rd_n && (addr != SEL_CTL);
endmodule

// File: rtl/pio_mode_reg.sv
// Holds the mode and direction configuration loaded by a mode word.
// Assumes wr_mode is already qualified; bit 7 of the word is not needed here.
module pio_mode_reg
    import pio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_mode,
    input  logic [6:0] word,
    output pio_cfg_t cfg
);
    // Load the configuration fields; group A code 2 covers both 1x encodings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= PIO_CFG_RST;
        end else if (wr_mode) begin
            cfg.a_mode <= word[6] ? GA_BIDIR : (word[5] ? GA_STROBED : GA_BASIC);
            cfg.a_in   <= word[4];
            cfg.ch_in  <= word[3];
            cfg.b_mode <= word[2];
            cfg.b_in   <= word[1];
            cfg.cl_in  <= word[0];
        end
    end
endmodule

// File: rtl/pio_port_latch.sv
// One port output latch with byte load, clear, and optional single-bit update.
// Assumes the three write controls are mutually exclusive per cycle.
module pio_port_latch #(
    parameter int DW      = 8,
    parameter bit HAS_BIT = 1'b0,
    localparam int SELW   = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_byte,
    input  logic          wr_clr,
    input  logic          wr_bit,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    // Clear on reset or mode word, load a byte, or update one selected bit.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_clr) begin
            q <= '0;
        end else if (wr_byte) begin
            q <= wdata;
        end else if (HAS_BIT && wr_bit) begin
            q[wdata[SELW:1]] <= wdata[0];
        end
    end
endmodule

// File: rtl/pio_latch_bank.sv
// Output latches of all ports; only the last port accepts bit commands.
// Assumes port index order A, B, C matches the address decode.
module pio_latch_bank
    import pio_pkg::*;
#(
    parameter int DW    = PIO_DW,
    parameter int NPORT = PIO_NPORT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPORT-1:0]           wr_lat,
    input  logic                       wr_mode,
    input  logic                       wr_bit,
    input  logic [DW-1:0]              wdata,
    output logic [NPORT-1:0][DW-1:0]   lat
);
    // One latch per port, bit update enabled on the final one.
    for (genvar p = 0; p < NPORT; p++) begin : g_lat
        pio_port_latch #(
            .DW      (DW),
            .HAS_BIT (p == NPORT - 1)
        ) i_lat (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_byte (wr_lat[p]),
            .wr_clr  (wr_mode),
            .wr_bit  (wr_bit),
            .wdata   (wdata),
            .q       (lat[p])
        );
    end
endmodule

// File: rtl/pio_inte_reg.sv
// Interrupt-enable flip-flops loaded by bit commands in strobed modes.
// Assumes group A uses bits 4 (input side) and 6 (output side), group B bit 2.
module pio_inte_reg
    import pio_pkg::*;
#(
    parameter int SELW   = PIO_SELW,
    parameter int A_IN   = 4,
    parameter int A_OUT  = 6,
    parameter int B_BIT  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_bit,
    input  logic [SELW-1:0] bit_sel,
    input  logic            bit_val,
    input  ga_mode_e        a_mode,
    input  logic            b_mode,
    output logic            inte_a_in,
    output logic            inte_a_out,
    output logic            inte_b
);
    logic a_strobed;

    // Group A handshake is present in both non-basic modes.
    assign a_strobed = (a_mode != GA_BASIC);

    // Load each enable only when its group's handshake exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inte_a_in  <= 1'b0;
            inte_a_out <= 1'b0;
            inte_b     <= 1'b0;
        end else if (wr_bit) begin
            if (a_strobed && bit_sel == SELW'(A_IN))  inte_a_in  <= bit_val;
            if (a_strobed && bit_sel == SELW'(A_OUT)) inte_a_out <= bit_val;
            if (b_mode    && bit_sel == SELW'(B_BIT)) inte_b     <= bit_val;
        end
    end
endmodule

// File: rtl/pio_read_mux.sv
// Read data selection: pin level for inputs, latch for outputs, per nibble on C.
// Assumes rd_drive already excludes the control address.
module pio_read_mux
    import pio_pkg::*;
#(
    parameter int DW = PIO_DW,
    localparam int NW = DW / 2
) (
    input  logic [1:0]    addr,
    input  logic          rd_drive,
    input  logic          a_in,
    input  logic          b_in,
    input  logic          ch_in,
    input  logic          cl_in,
    input  logic [DW-1:0] pin_a,
    input  logic [DW-1:0] pin_b,
    input  logic [DW-1:0] pin_c,
    input  logic [DW-1:0] lat_a,
    input  logic [DW-1:0] lat_b,
    input  logic [DW-1:0] lat_c,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe
);
    logic [DW-1:0] c_mask;
    logic [DW-1:0] sel_val;

    // Per-bit input mask for port C built from the two nibble directions.
    assign c_mask = {{NW{ch_in}}, {NW{cl_in}}};

    // Choose the addressed port's view.
    always_comb begin
        unique case (addr)
            SEL_PA:  sel_val = a_in ? pin_a : lat_a;
            SEL_PB:  sel_val = b_in ? pin_b : lat_b;
            SEL_PC:  sel_val = (pin_c & c_mask) | (lat_c & ~c_mask);
            default: sel_val = '0;
        endcase
    end

    // Drive zero whenever the bus is not enabled.
    assign rdata    = rd_drive ? sel_val : '0;
    assign rdata_oe = rd_drive;
endmodule

// File: rtl/pio_ctrl_decoder.sv
// Top of the parallel I/O host register decoder.
// Assumes host strobes are synchronous to clk and sampled once per cycle.
module pio_ctrl_decoder
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rdata_oe,
    input  logic [7:0] pin_a,
    input  logic [7:0] pin_b,
    input  logic [7:0] pin_c,
    output logic [1:0] grp_a_mode,
    output logic       grp_b_mode,
    output logic       a_is_in,
    output logic       ch_is_in,
    output logic       b_is_in,
    output logic       cl_is_in,
    output logic [7:0] out_a,
    output logic [7:0] out_b,
    output logic [7:0] out_c,
    output logic       inte_a_in,
    output logic       inte_a_out,
    output logic       inte_b
);
    logic [PIO_NPORT-1:0]             wr_lat;
    logic                             wr_mode;
    logic                             wr_bit;
    logic                             rd_drive;
    pio_cfg_t                         cfg;
    logic [PIO_NPORT-1:0][PIO_DW-1:0] lat;

    pio_bus_decode #(.NPORT(PIO_NPORT)) i_dec (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .fmt_bit  (wdata[7]),
        .wr_lat   (wr_lat),
        .wr_mode  (wr_mode),
        .wr_bit   (wr_bit),
        .rd_drive (rd_drive)
    );

    pio_mode_reg i_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mode (wr_mode),
        .word    (wdata[6:0]),
        .cfg     (cfg)
    );

    pio_latch_bank #(.DW(PIO_DW), .NPORT(PIO_NPORT)) i_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lat  (wr_lat),
        .wr_mode (wr_mode),
        .wr_bit  (wr_bit),
        .wdata   (wdata),
        .lat     (lat)
    );

    pio_inte_reg i_inte (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_bit     (wr_bit),
        .bit_sel    (wdata[PIO_SELW:1]),
        .bit_val    (wdata[0]),
        .a_mode     (cfg.a_mode),
        .b_mode     (cfg.b_mode),
        .inte_a_in  (inte_a_in),
        .inte_a_out (inte_a_out),
        .inte_b     (inte_b)
    );

    pio_read_mux #(.DW(PIO_DW)) i_rd (
        .addr     (addr),
        .rd_drive (rd_drive),
        .a_in     (cfg.a_in),
        .b_in     (cfg.b_in),
        .ch_in    (cfg.ch_in),
        .cl_in    (cfg.cl_in),
        .pin_a    (pin_a),
        .pin_b    (pin_b),
        .pin_c    (pin_c),
        .lat_a    (lat[0]),
        .lat_b    (lat[1]),
        .lat_c    (lat[2]),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    // Present configuration and latches on the ports.
    assign grp_a_mode = cfg.a_mode;
    assign grp_b_mode = cfg.b_mode;
    assign a_is_in    = cfg.a_in;
    assign ch_is_in   = cfg.ch_in;
    assign b_is_in    = cfg.b_in;
    assign cl_is_in   = cfg.cl_in;
    assign out_a      = lat[0];
    assign out_b      = lat[1];
    assign out_c      = lat[2];
endmodule

// File: rtl/pio_ctrl_checker.sv
// Port-level properties of the register decoder, bound to the top module.
// Assumes the synchronous active-low reset of the design.
module pio_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       rdata_oe,
    input logic [1:0] grp_a_mode,
    input logic       grp_b_mode,
    input logic [7:0] out_a,
    input logic [7:0] out_b,
    input logic [7:0] out_c,
    input logic       inte_a_in,
    input logic       inte_a_out,
    input logic       inte_b
);
    logic ctl_wr;
    assign ctl_wr = !cs_n && !wr_n && rd_n && (addr == 2'b11);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(out_a) && $stable(out_b) && $stable(out_c) &&
                  $stable(grp_a_mode) && $stable(grp_b_mode)));

    assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !rdata_oe);

    assert_mode_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[7]) |=> (out_a == 8'h00 && out_b == 8'h00 && out_c == 8'h00));

    assert_bit_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[7]) |=> (out_c[$past(wdata[3:1])] == $past(wdata[0])));

    assert_bit_others_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[7]) |=>
            (((out_c ^ $past(out_c)) & ~(8'h01 << $past(wdata[3:1]))) == 8'h00));

    assert_inte_a_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[7] && grp_a_mode == 2'd0) |=>
            ($stable(inte_a_in) && $stable(inte_a_out)));

    assert_inte_b_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[7] && !grp_b_mode) |=> $stable(inte_b));

    assert_inte_a_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[7] && grp_a_mode != 2'd0 && wdata[3:1] == 3'd4) |=>
            (inte_a_in == $past(wdata[0])));

    assert_bus_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (!cs_n && !rd_n && addr != 2'b11));

    assert_bus_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == 8'h00));

    assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !wr_n) |=> ($stable(out_a) && $stable(out_b) && $stable(out_c) &&
                              $stable(inte_a_in) && $stable(inte_b)));
endmodule

bind pio_ctrl_decoder pio_ctrl_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .rdata_oe   (rdata_oe),
    .grp_a_mode (grp_a_mode),
    .grp_b_mode (grp_b_mode),
    .out_a      (out_a),
    .out_b      (out_b),
    .out_c      (out_c),
    .inte_a_in  (inte_a_in),
    .inte_a_out (inte_a_out),
    .inte_b     (inte_b)
);

// File: tb/test_pio_ctrl_decoder.sv
// Bench for the register decoder: directed corners plus seeded random traffic.
module test_pio_ctrl_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic [7:0] pin_a = 8'h00, pin_b = 8'h00, pin_c = 8'h00;
    logic [1:0] grp_a_mode;
    logic       grp_b_mode, a_is_in, ch_is_in, b_is_in, cl_is_in;
    logic [7:0] out_a, out_b, out_c;
    logic       inte_a_in, inte_a_out, inte_b;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Bench model state.
    logic [1:0] m_amode;
    logic       m_bmode, m_ain, m_chin, m_bin, m_clin;
    logic [7:0] m_la, m_lb, m_lc;
    logic       m_ia_in, m_ia_out, m_ib;

    always #5 clk = ~clk;

    pio_ctrl_decoder i_pio_ctrl_decoder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
        .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode),
        .a_is_in(a_is_in), .ch_is_in(ch_is_in), .b_is_in(b_is_in), .cl_is_in(cl_is_in),
        .out_a(out_a), .out_b(out_b), .out_c(out_c),
        .inte_a_in(inte_a_in), .inte_a_out(inte_a_out), .inte_b(inte_b)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_amode = 2'd0; m_bmode = 1'b0;
        m_ain = 1'b1; m_chin = 1'b1; m_bin = 1'b1; m_clin = 1'b1;
        m_la = 8'h00; m_lb = 8'h00; m_lc = 8'h00;
        m_ia_in = 1'b0; m_ia_out = 1'b0; m_ib = 1'b0;
    endtask

    // Requirement-level model of one accepted write.
    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'd0: m_la = d;
            2'd1: m_lb = d;
            2'd2: m_lc = d;
            default: begin
                if (d[7]) begin
                    m_amode = d[6] ? 2'd2 : {1'b0, d[5]};
                    m_ain = d[4]; m_chin = d[3]; m_bmode = d[2];
                    m_bin = d[1]; m_clin = d[0];
                    m_la = 8'h00; m_lb = 8'h00; m_lc = 8'h00;
                end else begin
                    m_lc[d[3:1]] = d[0];
                    if (m_amode != 2'd0 && d[3:1] == 3'd4) m_ia_in = d[0];
                    if (m_amode != 2'd0 && d[3:1] == 3'd6) m_ia_out = d[0];
                    if (m_bmode && d[3:1] == 3'd2) m_ib = d[0];
                end
            end
        endcase
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_ain ? pin_a : m_la;
            2'd1: return m_bin ? pin_b : m_lb;
            2'd2: return {m_chin ? pin_c[7:4] : m_lc[7:4], m_clin ? pin_c[3:0] : m_lc[3:0]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [63:0] dut_state();
        return {30'd0, grp_a_mode, grp_b_mode, a_is_in, ch_is_in, b_is_in, cl_is_in,
                out_a, out_b, out_c, inte_a_in, inte_a_out, inte_b};
    endfunction

    function automatic logic [63:0] mdl_state();
        return {30'd0, m_amode, m_bmode, m_ain, m_chin, m_bin, m_clin,
                m_la, m_lb, m_lc, m_ia_in, m_ia_out, m_ib};
    endfunction

    // One selected write cycle, then compare all state outputs.
    task automatic do_write(input logic [1:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        model_write(a, d);
        chk(req, dut_state(), mdl_state());
    endtask

    // One read cycle with given pin levels; sampled after inputs settle.
    task automatic do_read(input logic [1:0] a, input logic [7:0] pa, input logic [7:0] pb,
                           input logic [7:0] pc, input string req);
        @(negedge clk);
        pin_a = pa; pin_b = pb; pin_c = pc;
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = a;
        #1;
        chk(req, {55'd0, rdata_oe, rdata}, {55'd0, (a != 2'd3), exp_read(a)});
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state.
        chk("R9 reset", dut_state(), mdl_state());

        // R1: port latch writes.
        do_write(2'd0, 8'h5A, "R1 port A");
        do_write(2'd1, 8'hC3, "R1 port B");
        do_write(2'd2, 8'h81, "R1 port C");

        // R2: deselected write and read have no effect.
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; wdata = 8'hFF;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b0;
        #1;
        chk("R2 no write", dut_state(), mdl_state());
        chk("R2 bus off", {63'd0, rdata_oe}, 64'd0);
        rd_n = 1'b1;

        // R4 and R3: mode word clears latches and loads fields.
        do_write(2'd3, 8'h95, "R4 R3 mode word 95");
        do_write(2'd3, 8'hA0, "R3 group A mode 1");
        do_write(2'd3, 8'hC0, "R3 group A mode 2 (10)");
        do_write(2'd3, 8'hE0, "R3 group A mode 2 (11)");

        // R5: bit commands, ignored high bits.
        do_write(2'd3, 8'h80, "R3 all outputs");
        do_write(2'd3, 8'h0F, "R5 set bit 7");
        do_write(2'd3, 8'h77, "R5 set bit 3 with bits 6:4 set");
        do_write(2'd3, 8'h0E, "R5 clear bit 7");

        // R6: enables hold in mode 0, load in strobed modes.
        do_write(2'd3, 8'h09, "R6 bit 4 in mode 0");
        do_write(2'd3, 8'h0D, "R6 bit 6 in mode 0");
        do_write(2'd3, 8'h05, "R6 bit 2 in mode 0");
        do_write(2'd3, 8'hA4, "R6 strobed modes");
        do_write(2'd3, 8'h09, "R6 load A input enable");
        do_write(2'd3, 8'h0D, "R6 load A output enable");
        do_write(2'd3, 8'h05, "R6 load B enable");
        do_write(2'd3, 8'h08, "R6 clear A input enable");

        // R7: reads of inputs, outputs and mixed nibbles.
        do_write(2'd3, 8'h99, "R3 A in, C high in, C low in");
        do_write(2'd1, 8'h3C, "R1 port B out");
        do_read(2'd0, 8'hA5, 8'h11, 8'h22, "R7 read A pins");
        do_read(2'd1, 8'hA5, 8'h11, 8'h22, "R7 read B latch");
        do_write(2'd3, 8'h91, "R3 C high out");
        do_write(2'd2, 8'hB7, "R1 port C latch");
        do_read(2'd2, 8'h00, 8'h00, 8'h4E, "R7 read C mixed nibbles");

        // R8: control address read does not drive.
        do_read(2'd3, 8'hFF, 8'hFF, 8'hFF, "R8 control read");

        // R10: write and read strobes together.
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; addr = 2'd1; wdata = 8'hEE;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        chk("R10 collision ignored", dut_state(), mdl_state());

        // Seeded random mix of writes and reads.
        void'($urandom(32'd20240601));
        for (int i = 0; i < 400; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            if ($urandom_range(0, 3) != 0)
                do_write(a, d, "R1 R3 R4 R5 R6 random write");
            else
                do_read(a, 8'($urandom), 8'($urandom), 8'($urandom), "R7 R8 random read");
        end

        // R9: reset again after traffic.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk("R9 reset after traffic", dut_state(), mdl_state());

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule